// File: doc/BRIEF.md
# Multi-mode 24-bit timer/counter

This peripheral holds one up-counter, 24 bits wide by default, that a processor configures through a small 32-bit register bus with per-byte write strobes and word reads. The counter serves three jobs, chosen by a two-bit mode field. In the interval job it counts to compare A and then either restarts or holds. In the pulse job it toggles an output flip-flop at compare A and again at compare B, and restarts after B. In the watchdog job it flags expiry at compare A and restarts. A fourth mode value parks the counter.

Counting is paced by a one-cycle `tick_i` strobe from a separate prescaler. The prescaler's divide value, divide enable and clock source choice are kept here and driven out to it. Each event sets a sticky status flag. A single write clears all the flags. The interrupt output is a level that stays high while any flag whose enable is set remains set. An asynchronous power-on reset and a synchronous soft reset are both provided. The soft reset also loads the flip-flop from a preset bit.

Top module: `mtimer24`

## Requirements
- R1: After reset, every register reads zero except compare A and compare B, which read all ones in the low CNT_W bits. `irq_o` and `ff_o` are 0.
- R2: The control word (offset 0x00) is written only through byte lane 0, and bit 4 always reads 0. Its layout is: bit 7 run, bit 6 divide enable, bit 5 clear-enable, bit 2 external source select, bits 1:0 mode (0 interval, 1 pulse, 2 watchdog, 3 off). A write with run=0 and clear-enable=1 zeroes the counter.
- R3: The counter changes only in cycles where `tick_i` is high, and it wraps modulo 2^CNT_W.
- R4: In interval mode the counter advances only while run=1 and the count differs from compare A. When the incremented count equals compare A, status bit 0 is set. The counter then restarts at 0 if zero-clear (interval word 0x10, bit 0) is 1, and otherwise holds at compare A.
- R5: In pulse mode, an incremented count equal to compare A toggles `ff_o` and sets status bit 1. An incremented count equal to compare B (A checked first) toggles `ff_o`, sets status bit 2 and zeroes the counter. The flip-flop changes in no other mode, except through the soft reset.
- R6: In watchdog mode a match with compare A sets status bit 3 and zeroes the counter. Counting continues with run=0 unless the disable bit (watchdog word 0x40, bit 7) is 1.
- R7: Mode 3 never counts. Interval and pulse modes do not count while run=0.
- R8: Any write that enables byte lane 0 at the status word (0x04) clears all four flags, and `irq_o` then falls.
- R9: `irq_o` is high exactly while some flag is set together with its enable. The enables are: interval word bit 15 for flag 0, pulse word (0x30) bit 14 for flag 1 and bit 15 for flag 2, and watchdog word bit 15 for flag 3.
- R10: A cycle with `srst_i` high returns all registers, the counter and the flags to their R1 values, and loads `ff_o` from pulse word bit 0.
- R11: Only the low three byte lanes of the compare words (0x08, 0x0C) are writable, truncated to CNT_W bits. The counter readback word (0xF0) ignores writes. Unmapped or misaligned addresses read zero.
- R12: The divider word (0x20) keeps bits 2:0. These bits drive `presc_div_o`, and control bits 6 and 2 drive `presc_div_en_o` and `presc_ext_sel_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous soft reset, loads flip-flop preset |
| tick_i | input | 1 | One-cycle count strobe from the prescaler |
| we_i | input | 1 | Register write request |
| addr_i | input | ADDR_W | Byte address of the register word |
| wdata_i | input | 32 | Write data |
| wstrb_i | input | 4 | Byte-lane write strobes |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt level |
| ff_o | output | 1 | Pulse flip-flop output |
| presc_div_o | output | 3 | Divide select for the prescaler |
| presc_div_en_o | output | 1 | Prescaler divide enable |
| presc_ext_sel_o | output | 1 | Prescaler external source select |

## Verification
The bench builds the timer with CNT_W = 8 and ADDR_W = 8. The narrow counter lets the default all-ones compare value and the modulo wrap be reached in a few hundred ticks. The same narrowing exercises the truncation of wide compare writes, where upper lane data must vanish. Register offsets and field positions do not depend on CNT_W, so every decode, mode and interrupt-enable path is exercised just as at full width.

// File: rtl/mtimer24_pkg.sv
`timescale 1ns/1ps
package mtimer24_pkg;

  typedef enum logic [1:0] {
    MODE_INTV  = 2'd0,
    MODE_PULSE = 2'd1,
    MODE_WDOG  = 2'd2,
    MODE_OFF   = 2'd3
  } tmr_mode_e;

  localparam int OFF_CTRL  = 'h00;
  localparam int OFF_STAT  = 'h04;
  localparam int OFF_CMPA  = 'h08;
  localparam int OFF_CMPB  = 'h0C;
  localparam int OFF_INTV  = 'h10;
  localparam int OFF_DIV   = 'h20;
  localparam int OFF_PULSE = 'h30;
  localparam int OFF_WDOG  = 'h40;
  localparam int OFF_CNT   = 'hF0;

  localparam int NUM_ST  = 4;
  localparam int ST_INTV = 0;
  localparam int ST_PA   = 1;
  localparam int ST_PB   = 2;
  localparam int ST_WD   = 3;

endpackage

// File: rtl/mtimer24_regs.sv
`timescale 1ns/1ps
module mtimer24_regs import mtimer24_pkg::*; #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      srst_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [31:0]               wdata_i,
  input  logic [3:0]                wstrb_i,
  input  logic [CNT_W-1:0]          cnt_i,
  input  logic [NUM_ST-1:0]         status_i,
  output logic [31:0]               rdata_o,
  output tmr_mode_e                 mode_o,
  output logic                      run_o,
  output logic                      intv_zc_o,
  output logic                      wd_dis_o,
  output logic                      ffi_o,
  output logic [NUM_ST-1:0]         ie_o,
  output logic [CNT_W-1:0]          cmpa_o,
  output logic [CNT_W-1:0]          cmpb_o,
  output logic                      cnt_clr_o,
  output logic                      stat_clr_o,
  output logic [2:0]                div_o,
  output logic                      div_en_o,
  output logic                      ext_sel_o
);

  localparam int WA_W = ADDR_W - 2;

  logic [7:0]       ctrl_q;
  logic             intv_ie_q, intv_zc_q;
  logic [2:0]       div_q;
  logic             pb_ie_q, pa_ie_q, ffi_q;
  logic             wd_ie_q, wd_dis_q, wd_clr_q;
  logic [CNT_W-1:0] cmpa_q, cmpb_q;

  logic [WA_W-1:0] word;
  logic            aligned;
  logic sel_ctrl, sel_stat, sel_cmpa, sel_cmpb, sel_intv, sel_div, sel_pulse, sel_wdog, sel_cnt;
  logic [23:0]     lane_mask;
  logic [CNT_W-1:0] cmp_mask;
  logic            w0, w1;

  assign word      = addr_i[ADDR_W-1:2];
  assign aligned   = (addr_i[1:0] == 2'b00);
  assign sel_ctrl  = aligned && (word == WA_W'(OFF_CTRL  >> 2));
  assign sel_stat  = aligned && (word == WA_W'(OFF_STAT  >> 2));
  assign sel_cmpa  = aligned && (word == WA_W'(OFF_CMPA  >> 2));
  assign sel_cmpb  = aligned && (word == WA_W'(OFF_CMPB  >> 2));
  assign sel_intv  = aligned && (word == WA_W'(OFF_INTV  >> 2));
  assign sel_div   = aligned && (word == WA_W'(OFF_DIV   >> 2));
  assign sel_pulse = aligned && (word == WA_W'(OFF_PULSE >> 2));
  assign sel_wdog  = aligned && (word == WA_W'(OFF_WDOG  >> 2));
  assign sel_cnt   = aligned && (word == WA_W'(OFF_CNT   >> 2));

  assign w0 = we_i && wstrb_i[0];
  assign w1 = we_i && wstrb_i[1];

  // compare words: lanes 0..2 only
  assign lane_mask = {{8{wstrb_i[2]}}, {8{wstrb_i[1]}}, {8{wstrb_i[0]}}};
  assign cmp_mask  = lane_mask[CNT_W-1:0];

  logic unused_bits;
  assign unused_bits = ^{wdata_i[31:24], wstrb_i[3]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      intv_ie_q <= 1'b0;
      intv_zc_q <= 1'b0;
      div_q     <= '0;
      pb_ie_q   <= 1'b0;
      pa_ie_q   <= 1'b0;
      ffi_q     <= 1'b0;
      wd_ie_q   <= 1'b0;
      wd_dis_q  <= 1'b0;
      wd_clr_q  <= 1'b0;
      cmpa_q    <= '1;
      cmpb_q    <= '1;
    end else if (srst_i) begin
      ctrl_q    <= '0;
      intv_ie_q <= 1'b0;
      intv_zc_q <= 1'b0;
      div_q     <= '0;
      pb_ie_q   <= 1'b0;
      pa_ie_q   <= 1'b0;
      ffi_q     <= 1'b0;
      wd_ie_q   <= 1'b0;
      wd_dis_q  <= 1'b0;
      wd_clr_q  <= 1'b0;
      cmpa_q    <= '1;
      cmpb_q    <= '1;
    end else begin
      if (w0 && sel_ctrl) ctrl_q <= wdata_i[7:0] & 8'hEF;
      if (w1 && sel_intv) intv_ie_q <= wdata_i[15];
      if (w0 && sel_intv) intv_zc_q <= wdata_i[0];
      if (w0 && sel_div)  div_q <= wdata_i[2:0];
      if (w1 && sel_pulse) begin
        pb_ie_q <= wdata_i[15];
        pa_ie_q <= wdata_i[14];
      end
      if (w0 && sel_pulse) ffi_q <= wdata_i[0];
      if (w1 && sel_wdog) wd_ie_q <= wdata_i[15];
      if (w0 && sel_wdog) begin
        wd_dis_q <= wdata_i[7];
        wd_clr_q <= wdata_i[0];
      end
      if (we_i && sel_cmpa)
        cmpa_q <= (cmpa_q & ~cmp_mask) | (wdata_i[CNT_W-1:0] & cmp_mask);
      if (we_i && sel_cmpb)
        cmpb_q <= (cmpb_q & ~cmp_mask) | (wdata_i[CNT_W-1:0] & cmp_mask);
    end
  end

  assign cnt_clr_o  = w0 && sel_ctrl && !wdata_i[7] && wdata_i[5];
  assign stat_clr_o = w0 && sel_stat;

  assign mode_o    = tmr_mode_e'(ctrl_q[1:0]);
  assign run_o     = ctrl_q[7];
  assign div_en_o  = ctrl_q[6];
  assign ext_sel_o = ctrl_q[2];
  assign div_o     = div_q;
  assign intv_zc_o = intv_zc_q;
  assign wd_dis_o  = wd_dis_q;
  assign ffi_o     = ffi_q;
  assign cmpa_o    = cmpa_q;
  assign cmpb_o    = cmpb_q;

  always_comb begin
    ie_o          = '0;
    ie_o[ST_INTV] = intv_ie_q;
    ie_o[ST_PA]   = pa_ie_q;
    ie_o[ST_PB]   = pb_ie_q;
    ie_o[ST_WD]   = wd_ie_q;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl)  rdata_o = {24'b0, ctrl_q};
    if (sel_stat)  rdata_o = 32'(status_i);
    if (sel_cmpa)  rdata_o = 32'(cmpa_q);
    if (sel_cmpb)  rdata_o = 32'(cmpb_q);
    if (sel_intv)  rdata_o = {16'b0, intv_ie_q, 14'b0, intv_zc_q};
    if (sel_div)   rdata_o = {29'b0, div_q};
    if (sel_pulse) rdata_o = {16'b0, pb_ie_q, pa_ie_q, 13'b0, ffi_q};
    if (sel_wdog)  rdata_o = {16'b0, wd_ie_q, 7'b0, wd_dis_q, 6'b0, wd_clr_q};
    if (sel_cnt)   rdata_o = 32'(cnt_i);
  end

  // control byte only through lane 0
  assert_ctrl_lane_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && !(we_i && wstrb_i[0] && sel_ctrl)) |=> $stable(ctrl_q));

  assert_srst_cmp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (cmpa_q == '1 && cmpb_q == '1 && ctrl_q == '0));

endmodule

// File: rtl/mtimer24_core.sv
`timescale 1ns/1ps
module mtimer24_core import mtimer24_pkg::*; #(
  parameter int CNT_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              tick_i,
  input  tmr_mode_e         mode_i,
  input  logic              run_i,
  input  logic              intv_zc_i,
  input  logic              wd_dis_i,
  input  logic              ffi_i,
  input  logic [CNT_W-1:0]  cmpa_i,
  input  logic [CNT_W-1:0]  cmpb_i,
  input  logic              cnt_clr_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ff_o,
  output logic [NUM_ST-1:0] evt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_nx, inc;
  logic             ff_q, ff_nx;
  logic             adv;

  assign inc = cnt_q + 1'b1;

  always_comb begin
    case (mode_i)
      MODE_INTV:  adv = run_i && (cnt_q != cmpa_i);
      MODE_PULSE: adv = run_i;
      MODE_WDOG:  adv = run_i || !wd_dis_i;
      default:    adv = 1'b0;
    endcase
    adv = adv && tick_i;
  end

  always_comb begin
    cnt_nx = cnt_q;
    ff_nx  = ff_q;
    evt_o  = '0;
    if (adv) begin
      cnt_nx = inc;
      case (mode_i)
        MODE_INTV: if (inc == cmpa_i) begin
          evt_o[ST_INTV] = 1'b1;
          if (intv_zc_i) cnt_nx = '0;
        end
        MODE_PULSE: begin
          if (inc == cmpa_i) begin
            ff_nx        = ~ff_q;
            evt_o[ST_PA] = 1'b1;
          end else if (inc == cmpb_i) begin
            ff_nx        = ~ff_q;
            evt_o[ST_PB] = 1'b1;
            cnt_nx       = '0;
          end
        end
        MODE_WDOG: if (inc == cmpa_i) begin
          evt_o[ST_WD] = 1'b1;
          cnt_nx       = '0;
        end
        default: ;
      endcase
    end
    if (cnt_clr_i) cnt_nx = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ff_q  <= 1'b0;
    end else if (srst_i) begin
      cnt_q <= '0;
      ff_q  <= ffi_i;
    end else begin
      cnt_q <= cnt_nx;
      ff_q  <= ff_nx;
    end
  end

  assign cnt_o = cnt_q;
  assign ff_o  = ff_q;

  assert_no_tick_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cnt_clr_i && !srst_i) |=> $stable(cnt_q));

  assert_hold_at_cmpa_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_INTV && cnt_q == cmpa_i && !cnt_clr_i && !srst_i) |=> (cnt_q == $past(cnt_q)));

  assert_ff_pulse_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srst_i && mode_i != MODE_PULSE) |=> $stable(ff_q));

  assert_off_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_OFF && !cnt_clr_i && !srst_i) |=> $stable(cnt_q));

  assert_evt_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(evt_o));

endmodule

// File: rtl/mtimer24_status.sv
`timescale 1ns/1ps
module mtimer24_status import mtimer24_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic [NUM_ST-1:0] evt_i,
  input  logic              clr_i,
  input  logic [NUM_ST-1:0] ie_i,
  output logic [NUM_ST-1:0] flags_o,
  output logic              irq_o
);

  logic [NUM_ST-1:0] flags_q;

  // a new event in the clearing cycle survives the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flags_q <= '0;
    else if (srst_i) flags_q <= '0;
    else             flags_q <= (clr_i ? '0 : flags_q) | evt_i;
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & ie_i);

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && evt_i == '0) |=> (flags_q == '0));

  assert_irq_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flags_q != '0));

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !srst_i) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

endmodule

// File: rtl/mtimer24.sv
`timescale 1ns/1ps
module mtimer24 import mtimer24_pkg::*; #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [3:0]        wstrb_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              ff_o,
  output logic [2:0]        presc_div_o,
  output logic              presc_div_en_o,
  output logic              presc_ext_sel_o
);

  tmr_mode_e         mode;
  logic              run, intv_zc, wd_dis, ffi, cnt_clr, stat_clr;
  logic [NUM_ST-1:0] ie, evt, flags;
  logic [CNT_W-1:0]  cmpa, cmpb, cnt;

  mtimer24_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .srst_i     (srst_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .wstrb_i    (wstrb_i),
    .cnt_i      (cnt),
    .status_i   (flags),
    .rdata_o    (rdata_o),
    .mode_o     (mode),
    .run_o      (run),
    .intv_zc_o  (intv_zc),
    .wd_dis_o   (wd_dis),
    .ffi_o      (ffi),
    .ie_o       (ie),
    .cmpa_o     (cmpa),
    .cmpb_o     (cmpb),
    .cnt_clr_o  (cnt_clr),
    .stat_clr_o (stat_clr),
    .div_o      (presc_div_o),
    .div_en_o   (presc_div_en_o),
    .ext_sel_o  (presc_ext_sel_o)
  );

  mtimer24_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .srst_i    (srst_i),
    .tick_i    (tick_i),
    .mode_i    (mode),
    .run_i     (run),
    .intv_zc_i (intv_zc),
    .wd_dis_i  (wd_dis),
    .ffi_i     (ffi),
    .cmpa_i    (cmpa),
    .cmpb_i    (cmpb),
    .cnt_clr_i (cnt_clr),
    .cnt_o     (cnt),
    .ff_o      (ff_o),
    .evt_o     (evt)
  );

  mtimer24_status u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .srst_i  (srst_i),
    .evt_i   (evt),
    .clr_i   (stat_clr),
    .ie_i    (ie),
    .flags_o (flags),
    .irq_o   (irq_o)
  );

endmodule

// File: tb/mtimer24_tb.sv
`timescale 1ns/1ps
module mtimer24_tb;

  localparam int CNT_W  = 8;
  localparam int ADDR_W = 8;
  localparam int WD_CYC = 200000;

  localparam int S_RD = 0, S_IRQ = 1, S_FF = 2, S_PRE = 3;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              srst_i = 1'b0;
  logic              tick_i = 1'b0;
  logic              we_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [3:0]        wstrb_i = '0;
  logic [31:0]       rdata_o;
  logic              irq_o, ff_o;
  logic [2:0]        presc_div_o;
  logic              presc_div_en_o, presc_ext_sel_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int          sel_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];
  event        chk_ev;

  always #2.5 clk_i = ~clk_i;

  mtimer24 #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst_i), .tick_i(tick_i),
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .wstrb_i(wstrb_i),
    .rdata_o(rdata_o), .irq_o(irq_o), .ff_o(ff_o),
    .presc_div_o(presc_div_o), .presc_div_en_o(presc_div_en_o),
    .presc_ext_sel_o(presc_ext_sel_o)
  );

  // monitor: pops one expected item per trigger and compares
  always begin
    @(chk_ev);
    #1;
    while (sel_q.size() > 0) begin
      automatic int          s = sel_q.pop_front();
      automatic logic [31:0] e = exp_q.pop_front();
      automatic string       t = tag_q.pop_front();
      automatic logic [31:0] a;
      case (s)
        S_RD:    a = rdata_o;
        S_IRQ:   a = {31'b0, irq_o};
        S_FF:    a = {31'b0, ff_o};
        default: a = {27'b0, presc_ext_sel_o, presc_div_en_o, presc_div_o};
      endcase
      n_run++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: actual=%h expected=%h", t, a, e);
      end
    end
  end

  // driver side: push expectation, let monitor sample
  task automatic chk(input int s, input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk_i);
    addr_i = a;
    sel_q.push_back(s);
    exp_q.push_back(e);
    tag_q.push_back(t);
    ->chk_ev;
    #2;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d; wstrb_i = s;
    @(negedge clk_i);
    we_i = 1'b0; wstrb_i = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
  endtask

  task automatic soft_reset();
    @(negedge clk_i); srst_i = 1'b1;
    @(negedge clk_i); srst_i = 1'b0;
  endtask

  initial begin
    #(WD_CYC * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    chk(S_RD, 8'h00, 32'h0, "R1 ctrl");
    chk(S_RD, 8'h04, 32'h0, "R1 status");
    chk(S_RD, 8'h08, 32'hFF, "R1 cmpa");
    chk(S_RD, 8'h0C, 32'hFF, "R1 cmpb");
    chk(S_RD, 8'h10, 32'h0, "R1 intv");
    chk(S_RD, 8'h30, 32'h0, "R1 pulse");
    chk(S_RD, 8'h40, 32'h0, "R1 wdog");
    chk(S_RD, 8'hF0, 32'h0, "R1 count");
    chk(S_IRQ, 8'h00, 32'h0, "R1 irq");
    chk(S_FF, 8'h00, 32'h0, "R1 ff");
    chk(S_RD, 8'h50, 32'h0, "R11 unmapped");

    // R12 prescaler fields, R2 bit-4 mask
    wr(8'h20, 32'hFFFF_FFFF, 4'b0001);
    chk(S_RD, 8'h20, 32'h7, "R12 divider");
    wr(8'h00, 32'h0000_00FF, 4'b0001);
    chk(S_RD, 8'h00, 32'hEF, "R2 bit4 masked");
    chk(S_PRE, 8'h00, 32'h1F, "R12 prescaler outputs");
    wr(8'h00, 32'h0000_FF00, 4'b0010);
    chk(S_RD, 8'h00, 32'hEF, "R2 upper lane ignored");
    chk(S_RD, 8'h01, 32'h0, "R11 misaligned");

    // R7 mode 3 with run set
    ticks(5);
    chk(S_RD, 8'hF0, 32'h0, "R7 mode off no count");

    // R11 compare truncation
    wr(8'h08, 32'hFFFF_FF05, 4'b1111);
    chk(S_RD, 8'h08, 32'h05, "R11 cmpa truncated");

    // R4 interval, hold variant
    wr(8'h10, 32'h0000_8000, 4'b0011);
    wr(8'h00, 32'h0000_0080, 4'b0001);
    ticks(4);
    chk(S_RD, 8'hF0, 32'h4, "R4 count before match");
    chk(S_RD, 8'h04, 32'h0, "R4 no flag yet");
    ticks(1);
    chk(S_RD, 8'hF0, 32'h5, "R4 reach cmpa");
    chk(S_RD, 8'h04, 32'h1, "R4 interval flag");
    chk(S_IRQ, 8'h00, 32'h1, "R9 interval irq");
    ticks(3);
    chk(S_RD, 8'hF0, 32'h5, "R4 holds at cmpa");
    wr(8'h04, 32'h0, 4'b0001);
    chk(S_RD, 8'h04, 32'h0, "R8 clear flags");
    chk(S_IRQ, 8'h00, 32'h0, "R8 irq drops");
    ticks(3);
    chk(S_RD, 8'h04, 32'h0, "R4 no re-flag while holding");

    // R2 counter clear, R7 run=0
    wr(8'h00, 32'h0000_0020, 4'b0001);
    chk(S_RD, 8'hF0, 32'h0, "R2 clear counter");
    ticks(3);
    chk(S_RD, 8'hF0, 32'h0, "R7 interval stopped");

    // R4 zero-clear variant, R9 enable off
    wr(8'h10, 32'h0000_0001, 4'b0011);
    wr(8'h00, 32'h0000_0080, 4'b0001);
    ticks(5);
    chk(S_RD, 8'hF0, 32'h0, "R4 zero-clear restart");
    chk(S_RD, 8'h04, 32'h1, "R4 flag on zero-clear");
    chk(S_IRQ, 8'h00, 32'h0, "R9 masked irq");
    ticks(2);
    chk(S_RD, 8'hF0, 32'h2, "R4 counting after restart");
    repeat (10) @(negedge clk_i);
    chk(S_RD, 8'hF0, 32'h2, "R3 no tick no change");
    wr(8'hF0, 32'h0000_0077, 4'b1111);
    chk(S_RD, 8'hF0, 32'h2, "R11 readback write ignored");

    // R5 pulse mode
    wr(8'h04, 32'h0, 4'b0001);
    wr(8'h00, 32'h0000_0020, 4'b0001);
    wr(8'h08, 32'h0000_0003, 4'b1111);
    wr(8'h0C, 32'h0000_0006, 4'b1111);
    wr(8'h30, 32'h0000_4000, 4'b0011);
    wr(8'h00, 32'h0000_0081, 4'b0001);
    ticks(3);
    chk(S_FF, 8'h00, 32'h1, "R5 toggle at cmpa");
    chk(S_RD, 8'h04, 32'h2, "R5 flag A");
    chk(S_IRQ, 8'h00, 32'h1, "R9 pulse A irq");
    wr(8'h04, 32'h0, 4'b0001);
    chk(S_IRQ, 8'h00, 32'h0, "R8 irq drops pulse");
    ticks(3);
    chk(S_FF, 8'h00, 32'h0, "R5 toggle at cmpb");
    chk(S_RD, 8'h04, 32'h4, "R5 flag B");
    chk(S_RD, 8'hF0, 32'h0, "R5 cleared at cmpb");
    chk(S_IRQ, 8'h00, 32'h0, "R9 B disabled");

    // R3 wrap with max compares
    wr(8'h04, 32'h0, 4'b0001);
    wr(8'h00, 32'h0000_0020, 4'b0001);
    wr(8'h08, 32'h0000_00FF, 4'b1111);
    wr(8'h0C, 32'h0000_00FF, 4'b1111);
    wr(8'h00, 32'h0000_0081, 4'b0001);
    ticks(255);
    chk(S_RD, 8'hF0, 32'hFF, "R3 reach max");
    chk(S_FF, 8'h00, 32'h1, "R5 toggle at max");
    ticks(1);
    chk(S_RD, 8'hF0, 32'h0, "R3 wrap to zero");
    chk(S_FF, 8'h00, 32'h1, "R5 no toggle on wrap");
    chk(S_RD, 8'h04, 32'h2, "R5 only flag A");

    // R6 watchdog
    wr(8'h04, 32'h0, 4'b0001);
    wr(8'h00, 32'h0000_0020, 4'b0001);
    wr(8'h08, 32'h0000_0004, 4'b1111);
    wr(8'h40, 32'h0000_8000, 4'b0011);
    wr(8'h00, 32'h0000_0002, 4'b0001);
    ticks(3);
    chk(S_RD, 8'hF0, 32'h3, "R6 counts with run=0");
    ticks(1);
    chk(S_RD, 8'hF0, 32'h0, "R6 expiry clears");
    chk(S_RD, 8'h04, 32'h8, "R6 watchdog flag");
    chk(S_IRQ, 8'h00, 32'h1, "R9 watchdog irq");
    wr(8'h40, 32'h0000_8080, 4'b0011);
    ticks(2);
    chk(S_RD, 8'hF0, 32'h0, "R6 disabled stops");
    wr(8'h00, 32'h0000_0082, 4'b0001);
    ticks(2);
    chk(S_RD, 8'hF0, 32'h2, "R6 run overrides disable");

    // R10 soft reset and flip-flop preset
    wr(8'h30, 32'h0000_0001, 4'b0001);
    soft_reset();
    chk(S_FF, 8'h00, 32'h1, "R10 ff preset from ffi");
    chk(S_RD, 8'h00, 32'h0, "R10 ctrl cleared");
    chk(S_RD, 8'h04, 32'h0, "R10 flags cleared");
    chk(S_RD, 8'h08, 32'hFF, "R10 cmpa restored");
    chk(S_RD, 8'hF0, 32'h0, "R10 count cleared");
    chk(S_RD, 8'h30, 32'h0, "R10 pulse cleared");
    chk(S_IRQ, 8'h00, 32'h0, "R10 irq low");
    soft_reset();
    chk(S_FF, 8'h00, 32'h0, "R10 ff preset zero");

    @(negedge clk_i);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule